// File: doc/BRIEF.md
# Media Register Move Unit

This block is the writeback datapath for the move and clear forms of a 128-bit media register file. It holds three register files, one of 128-bit vector registers, one of 64-bit legacy media registers and one of 64-bit general registers. It also drives a single-cycle memory port, with a combinational load path and a registered store path. A 4-bit operation code selects one of fifteen copy forms. For each form the unit reads the source and trims it to the form's width. It then zero-extends the result into the destination, or hands it to the store port.

The aligned 128-bit memory forms check the low four address bits. If any of them is set, the unit raises a fault for one cycle and drops the whole operation. Copies never modify their source. Writes commit on the clock edge that samples a valid operation, and every register can be read back combinationally through a peek port.

Top module: `mmv_move_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every register in all three files is cleared to zero, and `fault` and `st_en` are low after that edge.
- R2: Code 1 writes the low 32 bits of general register `src_idx` into vector register `dst_idx`, and code 2 writes its full 64 bits there. Every other bit of the destination becomes zero.
- R3: `ld_addr` equals `mem_addr` in the same cycle. Code 3 writes `ld_data[63:0]` into vector register `dst_idx`, with bits 127:64 cleared.
- R4: Code 4 writes the low 32 bits of vector register `src_idx` into general register `dst_idx` with bits 63:32 cleared. Code 5 writes the low 64 bits.
- R5: Code 6 stores the low 64 bits of vector register `src_idx`. On the edge after the operation it raises `st_en` for one cycle, with `st_addr` equal to `mem_addr`, `st_mask` equal to 16'h00FF, and `st_data` holding the 64 bits zero-extended.
- R6: Code 7 copies the low 64 bits of vector register `src_idx` into vector register `dst_idx` and clears the upper 64 bits. Code 8 copies all 128 bits.
- R7: Codes 9 (aligned) and 10 (unaligned) load all 16 bytes of `ld_data` into vector register `dst_idx`. Codes 11 (aligned) and 12 (unaligned) store vector register `src_idx` with `st_mask` equal to 16'hFFFF. The unaligned forms accept any address.
- R8: If code 9 or 11 is presented with a nonzero `mem_addr[3:0]`, `fault` is high for the cycle after the edge, and neither a register write nor a store takes place.
- R9: Code 13 writes the low 64 bits of vector register `src_idx` into legacy register `dst_idx`. Code 14 writes legacy register `src_idx` into the low half of vector register `dst_idx` and zeroes the upper half.
- R10: Code 15 writes the XOR of vector registers `src_idx` and `src2_idx` into vector register `dst_idx`. When the two indices are equal, the result is all zeros.
- R11: The source register of every copy form keeps its value, unless it is also the destination.
- R12: Code 0, and any cycle with `op_valid` low, writes no register and raises neither `st_en` nor `fault`.
- R13: A register write is visible on `pk_data` right after the committing edge, so back-to-back operations see each other's results. `pk_kind` selects the file: 0 vector, 1 legacy (zero-extended), 2 general (zero-extended), 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Move form selector |
| dst_idx | input | IDX_W | Destination register index |
| src_idx | input | IDX_W | Source register index |
| src2_idx | input | IDX_W | Second vector source (XOR form) |
| mem_addr | input | ADDR_W | Byte address for memory forms |
| ld_addr | output | ADDR_W | Load address to memory model |
| ld_data | input | 128 | 16 bytes read from ld_addr, byte 0 in bits 7:0 |
| st_en | output | 1 | Store strobe, one cycle |
| st_addr | output | ADDR_W | Store byte address |
| st_mask | output | 16 | Per-byte store enable |
| st_data | output | 128 | Store data, byte 0 in bits 7:0 |
| fault | output | 1 | Misaligned aligned-form access |
| pk_kind | input | 2 | Peek file select |
| pk_idx | input | IDX_W | Peek register index |
| pk_data | output | 128 | Peeked register value |

## Verification
Directed sequences start by loading vector registers with full 128-bit patterns. Narrower moves then overwrite those registers, so that any upper bits left behind rather than cleared show up. Some operations reuse a register as both source and destination, and some issue back-to-back. These tell apart a correct write from a stale read and from a write that lands one cycle late. Aligned forms are tried both at addresses that are multiples of 16 and at addresses off by 1 to 15, which separates the fault path from the unaligned forms' accept-anything path. A seeded mix of random forms, indices and addresses then runs against the reference model, which also checks every source register after each operation.

// File: rtl/mmv_pkg.sv
package mmv_pkg;

  localparam int VEC_W  = 128;
  localparam int HALF_W = 64;
  localparam int WORD_W = 32;
  localparam int LANES  = VEC_W / 8;

  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_G2V32   = 4'd1,
    OP_G2V64   = 4'd2,
    OP_M2V64   = 4'd3,
    OP_V2G32   = 4'd4,
    OP_V2G64   = 4'd5,
    OP_V2M64   = 4'd6,
    OP_V2V64   = 4'd7,
    OP_V2V128  = 4'd8,
    OP_M2V128A = 4'd9,
    OP_M2V128U = 4'd10,
    OP_V2M128A = 4'd11,
    OP_V2M128U = 4'd12,
    OP_V2L64   = 4'd13,
    OP_L2V64   = 4'd14,
    OP_VXOR    = 4'd15
  } mv_op_e;

  typedef enum logic [1:0] {
    RK_VEC  = 2'd0,
    RK_LEG  = 2'd1,
    RK_GPR  = 2'd2,
    RK_NONE = 2'd3
  } rkind_e;

  typedef enum logic [2:0] {
    SRC_VEC  = 3'd0,
    SRC_VXOR = 3'd1,
    SRC_GPR  = 3'd2,
    SRC_LEG  = 3'd3,
    SRC_MEM  = 3'd4
  } srcsel_e;

  typedef enum logic [1:0] {
    WID_32  = 2'd0,
    WID_64  = 2'd1,
    WID_128 = 2'd2
  } wid_e;

  typedef struct packed {
    rkind_e  dst;
    srcsel_e src;
    wid_e    wid;
    logic    store;
    logic    align;
  } mv_ctl_t;

endpackage

// File: rtl/mmv_decode.sv
module mmv_decode
  import mmv_pkg::*;
(
  input  logic [3:0] op_code,
  output mv_ctl_t    ctl
);

  always_comb begin
    ctl.dst   = RK_NONE;
    ctl.src   = SRC_VEC;
    ctl.wid   = WID_128;
    ctl.store = 1'b0;
    ctl.align = 1'b0;
    case (mv_op_e'(op_code))
      OP_G2V32: begin
        ctl.dst = RK_VEC; ctl.src = SRC_GPR; ctl.wid = WID_32;
      end
      OP_G2V64: begin
        ctl.dst = RK_VEC; ctl.src = SRC_GPR; ctl.wid = WID_64;
      end
      OP_M2V64: begin
        ctl.dst = RK_VEC; ctl.src = SRC_MEM; ctl.wid = WID_64;
      end
      OP_V2G32: begin
        ctl.dst = RK_GPR; ctl.wid = WID_32;
      end
      OP_V2G64: begin
        ctl.dst = RK_GPR; ctl.wid = WID_64;
      end
      OP_V2M64: begin
        ctl.store = 1'b1; ctl.wid = WID_64;
      end
      OP_V2V64: begin
        ctl.dst = RK_VEC; ctl.wid = WID_64;
      end
      OP_V2V128: begin
        ctl.dst = RK_VEC;
      end
      OP_M2V128A: begin
        ctl.dst = RK_VEC; ctl.src = SRC_MEM; ctl.align = 1'b1;
      end
      OP_M2V128U: begin
        ctl.dst = RK_VEC; ctl.src = SRC_MEM;
      end
      OP_V2M128A: begin
        ctl.store = 1'b1; ctl.align = 1'b1;
      end
      OP_V2M128U: begin
        ctl.store = 1'b1;
      end
      OP_V2L64: begin
        ctl.dst = RK_LEG; ctl.wid = WID_64;
      end
      OP_L2V64: begin
        ctl.dst = RK_VEC; ctl.src = SRC_LEG; ctl.wid = WID_64;
      end
      OP_VXOR: begin
        ctl.dst = RK_VEC; ctl.src = SRC_VXOR;
      end
      default: ;
    endcase
  end

  // R7
  align_full_width_chk: assert final (!ctl.align || (ctl.wid == WID_128 && ctl.dst != RK_GPR));

endmodule

// File: rtl/mmv_regfile.sv
module mmv_regfile #(
  parameter int W     = 64,
  parameter int DEPTH = 8,
  parameter int N_RD  = 2,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] w_idx,
  input  logic [W-1:0]  w_data,
  input  logic [IW-1:0] r_idx  [N_RD],
  output logic [W-1:0]  r_data [N_RD]
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[w_idx] <= w_data;
    end
  end

  for (genvar g = 0; g < N_RD; g++) begin : g_rd
    assign r_data[g] = mem[r_idx[g]];
  end

  // R13
  wr_visible_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(w_idx)] == $past(w_data));

endmodule

// File: rtl/mmv_move_unit.sv
module mmv_move_unit
  import mmv_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int ADDR_W = 12,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic [IDX_W-1:0]  src_idx,
  input  logic [IDX_W-1:0]  src2_idx,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] ld_addr,
  input  logic [127:0]      ld_data,
  output logic              st_en,
  output logic [ADDR_W-1:0] st_addr,
  output logic [15:0]       st_mask,
  output logic [127:0]      st_data,
  output logic              fault,
  input  logic [1:0]        pk_kind,
  input  logic [IDX_W-1:0]  pk_idx,
  output logic [127:0]      pk_data
);

  localparam int ALIGN_B = $clog2(LANES);

  mv_ctl_t ctl;
  mmv_decode u_dec (.op_code(op_code), .ctl(ctl));

  // register files: vector has src, src2, peek; others src, peek
  logic [IDX_W-1:0]  vec_ri [3];
  logic [VEC_W-1:0]  vec_rd [3];
  logic [IDX_W-1:0]  leg_ri [2];
  logic [HALF_W-1:0] leg_rd [2];
  logic [IDX_W-1:0]  gpr_ri [2];
  logic [HALF_W-1:0] gpr_rd [2];

  assign vec_ri[0] = src_idx;
  assign vec_ri[1] = src2_idx;
  assign vec_ri[2] = pk_idx;
  assign leg_ri[0] = src_idx;
  assign leg_ri[1] = pk_idx;
  assign gpr_ri[0] = src_idx;
  assign gpr_ri[1] = pk_idx;

  logic              fault_now, go, st_go;
  logic              vec_we, leg_we, gpr_we;
  logic [VEC_W-1:0]  src_val, res;

  mmv_regfile #(.W(VEC_W), .DEPTH(NREG), .N_RD(3)) u_vec (
    .clk(clk), .rst(rst), .we(vec_we), .w_idx(dst_idx), .w_data(res),
    .r_idx(vec_ri), .r_data(vec_rd));

  mmv_regfile #(.W(HALF_W), .DEPTH(NREG), .N_RD(2)) u_leg (
    .clk(clk), .rst(rst), .we(leg_we), .w_idx(dst_idx), .w_data(res[HALF_W-1:0]),
    .r_idx(leg_ri), .r_data(leg_rd));

  mmv_regfile #(.W(HALF_W), .DEPTH(NREG), .N_RD(2)) u_gpr (
    .clk(clk), .rst(rst), .we(gpr_we), .w_idx(dst_idx), .w_data(res[HALF_W-1:0]),
    .r_idx(gpr_ri), .r_data(gpr_rd));

  assign ld_addr = mem_addr;

  // source select
  always_comb begin
    case (ctl.src)
      SRC_VEC:  src_val = vec_rd[0];
      SRC_VXOR: src_val = vec_rd[0] ^ vec_rd[1];
      SRC_GPR:  src_val = {{(VEC_W-HALF_W){1'b0}}, gpr_rd[0]};
      SRC_LEG:  src_val = {{(VEC_W-HALF_W){1'b0}}, leg_rd[0]};
      SRC_MEM:  src_val = ld_data;
      default:  src_val = '0;
    endcase
  end

  // width trim with zero-extension
  always_comb begin
    case (ctl.wid)
      WID_32:  res = {{(VEC_W-WORD_W){1'b0}}, src_val[WORD_W-1:0]};
      WID_64:  res = {{(VEC_W-HALF_W){1'b0}}, src_val[HALF_W-1:0]};
      default: res = src_val;
    endcase
  end

  assign fault_now = op_valid && ctl.align && (mem_addr[ALIGN_B-1:0] != '0);
  assign go        = op_valid && !fault_now;
  assign vec_we    = go && (ctl.dst == RK_VEC);
  assign leg_we    = go && (ctl.dst == RK_LEG);
  assign gpr_we    = go && (ctl.dst == RK_GPR);
  assign st_go     = go && ctl.store;

  // registered store port and fault flag
  always_ff @(posedge clk) begin
    if (rst) begin
      st_en   <= 1'b0;
      fault   <= 1'b0;
      st_addr <= '0;
      st_mask <= '0;
      st_data <= '0;
    end else begin
      st_en <= st_go;
      fault <= fault_now;
      if (st_go) begin
        st_addr <= mem_addr;
        st_data <= res;
        st_mask <= (ctl.wid == WID_64) ? 16'h00FF : 16'hFFFF;
      end
    end
  end

  // peek
  always_comb begin
    case (rkind_e'(pk_kind))
      RK_VEC:  pk_data = vec_rd[2];
      RK_LEG:  pk_data = {{(VEC_W-HALF_W){1'b0}}, leg_rd[1]};
      RK_GPR:  pk_data = {{(VEC_W-HALF_W){1'b0}}, gpr_rd[1]};
      default: pk_data = '0;
    endcase
  end

  // R8
  fault_cause_chk: assert property (@(posedge clk) disable iff (rst)
    fault |-> $past(op_valid) && ($past(mem_addr[ALIGN_B-1:0]) != '0));
  // R8
  fault_no_store_chk: assert property (@(posedge clk) disable iff (rst)
    fault |-> !st_en);
  // R12
  store_needs_op_chk: assert property (@(posedge clk) disable iff (rst)
    st_en |-> $past(op_valid) && ($past(op_code) != 4'd0));
  // R5
  store_mask_chk: assert property (@(posedge clk) disable iff (rst)
    st_en |-> (st_mask == 16'h00FF || st_mask == 16'hFFFF));
  // R7
  aligned_store_chk: assert property (@(posedge clk) disable iff (rst)
    (st_en && $past(op_code) == 4'd11) |-> (st_addr[ALIGN_B-1:0] == '0));
  // R10
  xor_self_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_we && op_code == 4'd15 && src_idx == src2_idx) |-> (res == '0));

endmodule

// File: tb/tb_mmv_move_unit.sv
module tb_mmv_move_unit;

  localparam int NREG = 8;
  localparam int AW   = 12;

  logic           clk = 1'b0;
  logic           rst;
  logic           op_valid;
  logic [3:0]     op_code;
  logic [2:0]     dst_idx, src_idx, src2_idx, pk_idx;
  logic [AW-1:0]  mem_addr, ld_addr, st_addr;
  logic [127:0]   ld_data, st_data, pk_data;
  logic           st_en, fault;
  logic [15:0]    st_mask;
  logic [1:0]     pk_kind;

  always #5 clk = ~clk;

  mmv_move_unit #(.NREG(NREG), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .dst_idx(dst_idx), .src_idx(src_idx), .src2_idx(src2_idx),
    .mem_addr(mem_addr), .ld_addr(ld_addr), .ld_data(ld_data),
    .st_en(st_en), .st_addr(st_addr), .st_mask(st_mask), .st_data(st_data),
    .fault(fault), .pk_kind(pk_kind), .pk_idx(pk_idx), .pk_data(pk_data));

  // bench memory and reference state
  logic [7:0]   bmem  [256];
  logic [127:0] m_vec [NREG];
  logic [63:0]  m_leg [NREG];
  logic [63:0]  m_gpr [NREG];
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always_comb begin
    for (int i = 0; i < 16; i++) ld_data[i*8 +: 8] = bmem[8'(ld_addr[7:0] + 8'(i))];
  end

  function automatic logic [127:0] window(input int a);
    logic [127:0] w;
    for (int i = 0; i < 16; i++) w[i*8 +: 8] = bmem[(a + i) & 255];
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] model_reg(input int k, input int i);
    case (k)
      0: return m_vec[i];
      1: return {64'b0, m_leg[i]};
      2: return {64'b0, m_gpr[i]};
      default: return '0;
    endcase
  endfunction

  task automatic peek_chk(input int k, input int i, input string req);
    pk_kind = 2'(k);
    pk_idx  = 3'(i);
    #1;
    chk(pk_data === model_reg(k, i), req, pk_data, model_reg(k, i));
  endtask

  // one operation; entered just after a negedge
  task automatic run_op(input int op, input int d, input int s, input int s2, input int a,
                        input bit vld, input string req);
    logic [127:0] sv, r;
    logic [15:0]  msk;
    int  dk = 3, sk = 3, wid = 128;
    bit  aln = 0, st = 0, flt;
    case (op)
      1:  begin sv = {64'b0, m_gpr[s]}; wid = 32; dk = 0; sk = 2; end
      2:  begin sv = {64'b0, m_gpr[s]}; wid = 64; dk = 0; sk = 2; end
      3:  begin sv = window(a); wid = 64; dk = 0; end
      4:  begin sv = m_vec[s]; wid = 32; dk = 2; sk = 0; end
      5:  begin sv = m_vec[s]; wid = 64; dk = 2; sk = 0; end
      6:  begin sv = m_vec[s]; wid = 64; st = 1; sk = 0; end
      7:  begin sv = m_vec[s]; wid = 64; dk = 0; sk = 0; end
      8:  begin sv = m_vec[s]; dk = 0; sk = 0; end
      9:  begin sv = window(a); dk = 0; aln = 1; end
      10: begin sv = window(a); dk = 0; end
      11: begin sv = m_vec[s]; st = 1; aln = 1; sk = 0; end
      12: begin sv = m_vec[s]; st = 1; sk = 0; end
      13: begin sv = m_vec[s]; wid = 64; dk = 1; sk = 0; end
      14: begin sv = {64'b0, m_leg[s]}; wid = 64; dk = 0; sk = 1; end
      15: begin sv = m_vec[s] ^ m_vec[s2]; dk = 0; sk = 0; end
      default: sv = '0;
    endcase
    if (wid == 32)      r = {96'b0, sv[31:0]};
    else if (wid == 64) r = {64'b0, sv[63:0]};
    else                r = sv;
    msk = (wid == 64) ? 16'h00FF : 16'hFFFF;
    flt = vld && aln && ((a % 16) != 0);
    if (!vld || flt) begin dk = 3; st = 0; end

    op_valid = vld;
    op_code  = 4'(op);
    dst_idx  = 3'(d);
    src_idx  = 3'(s);
    src2_idx = 3'(s2);
    mem_addr = AW'(a);
    #1;
    chk(ld_addr == AW'(a), "R3 ld_addr", 128'(ld_addr), 128'(a));
    @(posedge clk);
    #1;
    op_valid = 1'b0;
    op_code  = 4'd0;
    chk(fault == flt, {req, " fault"}, 128'(fault), 128'(flt));
    chk(st_en == st, {req, " st_en"}, 128'(st_en), 128'(st));
    if (st) begin
      chk(st_addr == AW'(a), {req, " st_addr"}, 128'(st_addr), 128'(a));
      chk(st_mask == msk, {req, " st_mask"}, 128'(st_mask), 128'(msk));
      chk(st_data == r, {req, " st_data"}, st_data, r);
      for (int i = 0; i < 16; i++) if (msk[i]) bmem[(a + i) & 255] = r[i*8 +: 8];
    end
    case (dk)
      0: m_vec[d] = r;
      1: m_leg[d] = r[63:0];
      2: m_gpr[d] = r[63:0];
      default: ;
    endcase
    if (dk != 3) peek_chk(dk, d, {req, " dest"});
    else if (op >= 1) begin
      // destination that could have been touched stays put
      peek_chk(0, d, {req, " untouched vec"});
      peek_chk(2, d, {req, " untouched gpr"});
    end
    if (sk != 3) peek_chk(sk, s, "R11 source kept");
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    for (int i = 0; i < NREG; i++) begin
      m_vec[i] = '0; m_leg[i] = '0; m_gpr[i] = '0;
    end
    rst = 1'b1; op_valid = 0; op_code = 0; dst_idx = 0; src_idx = 0; src2_idx = 0;
    mem_addr = 0; pk_kind = 0; pk_idx = 0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    chk(fault == 1'b0, "R1 fault after reset", 128'(fault), 0);
    chk(st_en == 1'b0, "R1 st_en after reset", 128'(st_en), 0);
    for (int i = 0; i < NREG; i++) begin
      peek_chk(0, i, "R1 vec clear");
      peek_chk(1, i, "R1 leg clear");
      peek_chk(2, i, "R1 gpr clear");
    end
    peek_chk(3, 0, "R13 kind 3 reads zero");
    @(negedge clk);

    run_op(9,  1, 0, 0, 16'h10, 1, "R7 aligned load");
    run_op(10, 2, 0, 0, 16'h23, 1, "R7 unaligned load");
    run_op(10, 3, 0, 0, 16'h40, 1, "R7 unaligned load");
    run_op(3,  3, 0, 0, 16'h05, 1, "R3 64-bit load clears upper");
    run_op(5,  0, 1, 0, 0,      1, "R4 vec to gpr 64");
    run_op(4,  1, 2, 0, 0,      1, "R4 vec to gpr 32");
    run_op(10, 4, 0, 0, 16'h61, 1, "R7 unaligned load");
    run_op(1,  4, 0, 0, 0,      1, "R2 gpr to vec 32");
    run_op(10, 5, 0, 0, 16'h70, 1, "R7 unaligned load");
    run_op(2,  5, 0, 0, 0,      1, "R2 gpr to vec 64");
    run_op(13, 0, 2, 0, 0,      1, "R9 vec to legacy");
    run_op(14, 1, 0, 0, 0,      1, "R9 legacy to vec clears upper");
    run_op(10, 6, 0, 0, 16'h33, 1, "R7 unaligned load");
    run_op(7,  6, 2, 0, 0,      1, "R6 low quad copy");
    run_op(8,  7, 3, 0, 0,      1, "R6 full copy");
    run_op(8,  7, 7, 0, 0,      1, "R6 copy onto itself");
    run_op(6,  0, 2, 0, 16'h80, 1, "R5 64-bit store");
    run_op(11, 0, 5, 0, 16'h90, 1, "R7 aligned store");
    run_op(12, 0, 6, 0, 16'hA7, 1, "R7 unaligned store");
    run_op(10, 0, 0, 0, 16'hA7, 1, "R7 reload of store");
    run_op(3,  2, 0, 0, 16'h80, 1, "R5 reload of 64-bit store");
    run_op(9,  1, 0, 0, 16'h31, 1, "R8 misaligned load faults");
    run_op(9,  1, 0, 0, 16'h3F, 1, "R8 misaligned load faults");
    run_op(11, 0, 2, 0, 16'h48, 1, "R8 misaligned store faults");
    run_op(9,  1, 0, 0, 16'h30, 1, "R8 aligned after fault");
    run_op(15, 6, 1, 2, 0,      1, "R10 xor");
    run_op(15, 3, 3, 3, 0,      1, "R10 xor self clears");
    run_op(0,  4, 5, 0, 16'h20, 1, "R12 code 0 no write");
    run_op(10, 4, 0, 0, 16'h20, 0, "R12 valid low no write");
    run_op(5,  2, 4, 0, 0,      1, "R13 back to back A");
    run_op(2,  7, 2, 0, 0,      1, "R13 back to back B");

    for (int k = 0; k < 120; k++) begin
      int op, d, s, s2, a;
      op = int'($urandom_range(0, 15));
      d  = int'($urandom_range(0, NREG - 1));
      s  = int'($urandom_range(0, NREG - 1));
      s2 = int'($urandom_range(0, NREG - 1));
      a  = int'($urandom_range(0, 239));
      if (k % 5 == 0) a = a & 8'hF0;
      run_op(op, d, s, s2, a, 1, "R13 mixed sequence");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule